// File: doc/BRIEF.md
# Column-Systolic Binary Template Correlator

This block correlates a binary template of 16 columns by 16 rows against a strip of 8-bit image pixels that arrives one pixel per clock. The pixels come column by column: all 16 rows of one image column arrive before the next column starts. The array has one processing element for each template column, and every element sees every pixel. When the template bit for the current row is set in an element's column, that element adds the pixel to its running partial sum. When an image column ends, each element passes its sum one place along the chain and takes over the sum of its left neighbour. The first element restarts from zero. The last element therefore completes one correlation per image column, for the offset whose left edge lies 15 columns back. Only the current image column has to be present at any time.

Template bits are written into a staging bank through a plain write port. A start-of-image token goes with the first pixel of an image. It flushes every partial sum still in flight, and it then moves down the chain at the pace of the image columns. Element k copies its column from the staging bank at the first pixel of image column k, and uses the copied bits from that pixel on. The input side is valid/ready with ready always high, so the source never sees back-pressure. A cycle with `in_valid` low is a bubble in which nothing advances. The output is a single-cycle strobe with no ready, so the consumer must take every strobe.

Top module: `colsys_corr`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0, and `in_ready` is 1 at all times after reset.
- R2: Each result equals the sum over template columns a (0..15) and rows b (0..15) of T(a,b)·P(x+a, b), where x is the result's offset, P(c,b) is row b of image column c, and T(a,b) is bit b of the `tpl_wr_bits` word last written with `tpl_wr_col` = a.
- R3: Counting from the token pixel, the n-th accepted pixel is row n mod 16 of image column n div 16. Row 0 is bit 0 of a template column word, and template column 0 meets the leftmost image column of an offset.
- R4: An image of W columns gives exactly W−15 results, for offsets 0, 1, … in order. Each result appears as `out_valid`=1 in the cycle after the pixel carrying row 15 of image column x+15 is accepted, and `out_valid` is never high in two consecutive cycles.
- R5: A cycle with `in_valid`=0 changes no result, no row position and no template. Bubbles inserted anywhere in the stream leave every result value unchanged and delay it by the number of bubbles.
- R6: A pixel with `in_first`=1 starts a new image at row 0, column 0, even in the middle of a column. Sums of the earlier image that are still in flight are dropped, and no result appears until column 15 of the new image completes.
- R7: Element k takes its template column from the staging bank at the first pixel of image column k. A staging write made after image column 15 has started does not change the remaining results of that image, and it takes effect from the next token onward.
- R8: After reset, pixels accepted before the first token produce no results.
- R9: The 16-bit sum does not wrap. With an all-ones template and every pixel at 255, each result is 65280.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pixel is presented this cycle |
| in_ready | output | 1 | Always 1 after reset; the stream never stalls |
| in_first | input | 1 | Token: this pixel is row 0 of column 0 of a new image |
| in_pixel | input | 8 | Pixel value |
| tpl_wr_en | input | 1 | Write one template column word into the staging bank |
| tpl_wr_col | input | 4 | Staging column to write |
| tpl_wr_bits | input | 16 | Column bits, bit b is row b |
| out_valid | output | 1 | Strobe: `out_sum` holds a completed correlation |
| out_sum | output | 16 | Correlation result |

## Verification
The bench goes after the phase of the column chain. A design that handed sums over one row too early or too late would still strobe at the right rate but give values shifted by a row, which single-bit templates at the opposite corners expose. A token arriving mid-column, followed at once by a new image, catches a design that keeps stale partial sums or strobes before column 15 of the new image. Bubbles inserted between pixels catch a design that advances its row counter on idle cycles. A staging rewrite in the middle of an image separates a design that copies template columns as the token reaches each element from one that reads the staging bank live. An all-255 image against an all-ones template catches a narrowed or wrapping accumulator.

// File: rtl/colsys_pkg.sv
package colsys_pkg;
  localparam int TPL_COLS = 16;
  localparam int TPL_ROWS = 16;
  localparam int PIX_W    = 8;
  localparam int SUM_W    = 16;
endpackage

// File: rtl/colsys_seq.sv
module colsys_seq #(
  parameter int ROWS = 16,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  output logic          beat,
  output logic          flush,
  output logic          col_end,
  output logic [RW-1:0] row_idx
);
  logic [RW-1:0] row_q;

  assign beat    = in_valid;
  assign flush   = in_valid && in_first;
  // a token forces the row position back to the top of a column
  assign row_idx = flush ? '0 : row_q;
  assign col_end = beat && (row_idx == RW'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (beat) begin
      row_q <= col_end ? '0 : row_idx + 1'b1;
    end
  end
endmodule

// File: rtl/colsys_tpl_bank.sv
module colsys_tpl_bank #(
  parameter int COLS = 16,
  parameter int ROWS = 16,
  localparam int CW = $clog2(COLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CW-1:0]        wr_col,
  input  logic [ROWS-1:0]      wr_bits,
  output logic [COLS*ROWS-1:0] bank_flat
);
  logic [ROWS-1:0] bank_q [COLS];

  for (genvar k = 0; k < COLS; k++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q[k] <= '0;
      end else if (wr_en && (int'(wr_col) == k)) begin
        bank_q[k] <= wr_bits;
      end
    end
    assign bank_flat[k*ROWS +: ROWS] = bank_q[k];
  end
endmodule

// File: rtl/colsys_pe.sv
module colsys_pe #(
  parameter int ROWS  = 16,
  parameter int PIX_W = 8,
  parameter int SUM_W = 16,
  parameter bit HEAD  = 1'b0,
  localparam int RW = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             flush,
  input  logic             col_end,
  input  logic [RW-1:0]    row_idx,
  input  logic [PIX_W-1:0] pix,
  input  logic [ROWS-1:0]  stage_bits,
  input  logic [SUM_W-1:0] sum_in,
  input  logic             tok_in,
  output logic [SUM_W-1:0] sum_out,
  output logic             tok_out
);
  logic [ROWS-1:0]  act_q;
  logic [SUM_W-1:0] acc_q;
  logic             pend_q;
  logic             newcol_q;
  logic             load_now;
  logic             bit_eff;
  logic [SUM_W-1:0] base;
  logic [SUM_W-1:0] add;

  // head element loads on the token pixel itself, others on the first
  // pixel of the column after the token reached their left neighbour
  assign load_now = HEAD ? flush : (pend_q && beat && !flush);
  assign bit_eff  = load_now ? stage_bits[row_idx] : act_q[row_idx];
  assign base     = (HEAD && flush) ? '0 : acc_q;
  assign add      = (beat && bit_eff) ? {{(SUM_W-PIX_W){1'b0}}, pix} : '0;
  assign sum_out  = base + add;
  assign tok_out  = newcol_q || load_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= '0;
      acc_q    <= '0;
      pend_q   <= 1'b0;
      newcol_q <= 1'b0;
    end else begin
      if (beat) acc_q <= col_end ? sum_in : sum_out;
      if (load_now) act_q <= stage_bits;

      if (flush)        pend_q <= 1'b0;
      else if (col_end) pend_q <= tok_in;
      else if (load_now) pend_q <= 1'b0;

      if (flush)         newcol_q <= HEAD;
      else if (col_end)  newcol_q <= 1'b0;
      else if (load_now) newcol_q <= 1'b1;
    end
  end
endmodule

// File: rtl/colsys_corr.sv
module colsys_corr
  import colsys_pkg::*;
#(
  parameter int COLS = TPL_COLS,
  parameter int ROWS = TPL_ROWS,
  parameter int PW   = PIX_W,
  parameter int SW   = SUM_W,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_first,
  input  logic [PW-1:0] in_pixel,
  input  logic          tpl_wr_en,
  input  logic [CW-1:0] tpl_wr_col,
  input  logic [ROWS-1:0] tpl_wr_bits,
  output logic          out_valid,
  output logic [SW-1:0] out_sum
);
  logic                 beat, flush, col_end;
  logic [RW-1:0]        row_idx;
  logic [COLS*ROWS-1:0] bank_flat;
  logic [SW-1:0]        pe_sum [COLS];
  logic                 pe_tok [COLS];
  logic                 tail_armed_q;
  logic                 out_valid_q;
  logic [SW-1:0]        out_sum_q;

  assign in_ready = 1'b1;

  colsys_seq #(.ROWS(ROWS)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .beat(beat), .flush(flush), .col_end(col_end), .row_idx(row_idx)
  );

  colsys_tpl_bank #(.COLS(COLS), .ROWS(ROWS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(tpl_wr_en), .wr_col(tpl_wr_col),
    .wr_bits(tpl_wr_bits), .bank_flat(bank_flat)
  );

  for (genvar k = 0; k < COLS; k++) begin : g_pe
    logic [SW-1:0] link_sum;
    logic          link_tok;
    if (k == 0) begin : g_head
      assign link_sum = '0;
      assign link_tok = 1'b0;
    end else begin : g_body
      assign link_sum = pe_sum[k-1];
      assign link_tok = pe_tok[k-1];
    end
    colsys_pe #(.ROWS(ROWS), .PIX_W(PW), .SUM_W(SW), .HEAD(k == 0)) u_pe (
      .clk(clk), .rst_n(rst_n), .beat(beat), .flush(flush),
      .col_end(col_end), .row_idx(row_idx), .pix(in_pixel),
      .stage_bits(bank_flat[k*ROWS +: ROWS]), .sum_in(link_sum),
      .tok_in(link_tok), .sum_out(pe_sum[k]), .tok_out(pe_tok[k])
    );
  end

  // the tail holds a sum of the current image once the token has reached it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_armed_q <= 1'b0;
      out_valid_q  <= 1'b0;
      out_sum_q    <= '0;
    end else begin
      if (flush) tail_armed_q <= 1'b0;
      else if (pe_tok[COLS-1]) tail_armed_q <= 1'b1;
      out_valid_q <= col_end && (tail_armed_q || pe_tok[COLS-1]);
      if (col_end) out_sum_q <= pe_sum[COLS-1];
    end
  end

  assign out_valid = out_valid_q;
  assign out_sum   = out_sum_q;
endmodule

// File: rtl/colsys_corr_chk.sv
module colsys_corr_chk #(
  parameter int COLS = 16,
  parameter int ROWS = 16,
  parameter int PW   = 8,
  parameter int SW   = 16,
  localparam int NW   = $clog2(ROWS*COLS) + 1,
  localparam int FULL = ROWS*COLS
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_first,
  input logic          out_valid,
  input logic [SW-1:0] out_sum
);
  logic          seen_tok_q;
  logic [NW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_tok_q <= 1'b0;
      since_q    <= '0;
    end else if (in_valid && in_first) begin
      seen_tok_q <= 1'b1;
      since_q    <= NW'(1);
    end else if (in_valid && int'(since_q) < FULL) begin
      since_q <= since_q + 1'b1;
    end
  end

  AST_NO_OUT_BEFORE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen_tok_q); // R8
  AST_FILL_BEFORE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(since_q) >= FULL); // R6
  AST_COLUMN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(since_q) % ROWS) == 0); // R3
  AST_ONE_PER_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R4
  AST_OUT_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R5
  AST_TOKEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first) |=> !out_valid); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_sum) <= FULL*((1 << PW) - 1)); // R9
endmodule

bind colsys_corr colsys_corr_chk #(.COLS(COLS), .ROWS(ROWS), .PW(PW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
  .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/test_colsys_corr.sv
`timescale 1ns/100ps
module test_colsys_corr;
  localparam int C = 16, R = 16, PW = 8, SW = 16, CW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, tpl_wr_en = 1'b0;
  logic [PW-1:0] in_pixel = '0;
  logic [CW-1:0] tpl_wr_col = '0;
  logic [R-1:0]  tpl_wr_bits = '0;
  logic in_ready, out_valid;
  logic [SW-1:0] out_sum;

  colsys_corr i_colsys_corr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_pixel(in_pixel), .tpl_wr_en(tpl_wr_en),
    .tpl_wr_col(tpl_wr_col), .tpl_wr_bits(tpl_wr_bits),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  int checks = 0, errors = 0;
  bit done = 0, ready_bad = 0, mon_on = 0;
  bit tplm [C][R];
  bit tpla [C][R];
  int img [64][R];
  bit img_on_m = 0;
  int col_m = 0, row_m = 0;
  int out_seen = 0, out_exp = 0;
  string cur_req = "R2";
  bit pend_v = 0, exp_v = 0;
  logic [SW-1:0] pend_d = '0, exp_d = '0;
  string pend_tag = "R2", exp_tag = "R2";

  // output monitor: exp_* describe the pixel taken at the preceding edge
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (in_ready !== 1'b1) ready_bad = 1;
      if (out_valid === 1'b1) out_seen++;
      if (out_valid === 1'b1 || exp_v) begin
        checks++;
        if (out_valid !== exp_v || (exp_v && out_sum !== exp_d)) begin
          errors++;
          $display("FAIL %s: valid=%0b sum=%0d expected valid=%0b sum=%0d",
                   exp_tag, out_valid, out_sum, exp_v, exp_d);
        end
      end
    end
  end

  task automatic step(input bit v, input bit f, input int pix,
                      input bit we, input int wcol, input int wbits,
                      input bit ev, input int ed);
    @(posedge clk);
    #1;
    exp_v = pend_v; exp_d = pend_d; exp_tag = pend_tag;
    in_valid = v; in_first = f; in_pixel = PW'(pix);
    tpl_wr_en = we; tpl_wr_col = CW'(wcol); tpl_wr_bits = R'(wbits);
    pend_v = ev; pend_d = SW'(ed); pend_tag = cur_req;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic int corr(input int x);
    int s = 0;
    for (int a = 0; a < C; a++)
      for (int b = 0; b < R; b++)
        if (tpla[a][b]) s += img[x+a][b];
    return s;
  endfunction

  // one accepted pixel, with the expected result computed from R2..R4
  task automatic pixel(input int pix, input bit first);
    bit ev = 0;
    int ed = 0;
    if (first) begin
      img_on_m = 1; col_m = 0; row_m = 0;
      tpla = tplm;
    end
    if (img_on_m) begin
      img[col_m][row_m] = pix;
      if (row_m == R-1 && col_m >= C-1) begin
        ev = 1; ed = corr(col_m - (C-1)); out_exp++;
      end
      row_m++;
      if (row_m == R) begin row_m = 0; col_m++; end
    end
    step(1, first, pix, 0, 0, 0, ev, ed);
  endtask

  function automatic bit tbit(input int p, input int a, input int b);
    case (p)
      0: return 1'b1;
      1: return ((a*5 + b*3 + 1) % 7) < 2;
      2: return a == b;
      3: return (a == 0 && b == 0) || (a == C-1 && b == R-1);
      4: return 1'b0;
      5: return (a == 0 && b == R-1);
      default: return ((a + b) % 2) == 0;
    endcase
  endfunction

  task automatic write_tpl(input int p);
    for (int a = 0; a < C; a++) begin
      int w = 0;
      for (int b = 0; b < R; b++) begin
        tplm[a][b] = tbit(p, a, b);
        if (tplm[a][b]) w |= (1 << b);
      end
      step(0, 0, 0, 1, a, w, 0, 0);
    end
  endtask

  function automatic int pgen(input int seed, input int c, input int r);
    if (seed < 0) return 255;
    return (c*29 + r*13 + seed*71 + c*r) & 255;
  endfunction

  // W columns; gap>0 inserts a bubble before every gap-th pixel;
  // wr_col>=0 rewrites the staging bank with pattern wr_pat there
  task automatic send_image(input int w, input int seed, input int gap,
                            input int wr_col, input int wr_pat);
    int n = 0;
    for (int c = 0; c < w; c++) begin
      if (c == wr_col) write_tpl(wr_pat);
      for (int r = 0; r < R; r++) begin
        if (gap > 0 && n % gap == gap-1) idle(1 + n % 2);
        pixel(pgen(seed, c, r), (c == 0 && r == 0));
        n++;
      end
    end
  endtask

  task automatic count_check(input string req);
    idle(4);
    checks++;
    if (out_seen != out_exp) begin
      errors++;
      $display("FAIL %s: result count=%0d expected=%0d", req, out_seen, out_exp);
    end
    out_seen = 0; out_exp = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < C; a++) for (int b = 0; b < R; b++) tplm[a][b] = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R1: out_valid in reset=%0b expected=0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: after reset valid=%0b ready=%0b expected valid=0 ready=1",
               out_valid, in_ready);
    end
    mon_on = 1;

    // R8: pixels with no token yet give nothing
    cur_req = "R8";
    write_tpl(0);
    for (int i = 0; i < 300; i++) pixel(i & 255, 0);
    count_check("R8");

    // R2: several templates and images
    cur_req = "R2";
    for (int p = 0; p < 5; p++) begin
      write_tpl(p);
      send_image(20, p, 0, -1, 0);
      count_check("R2");
    end

    // R3: single bits at the corners pin the row and column phase
    cur_req = "R3";
    write_tpl(5);
    send_image(19, 7, 0, -1, 0);
    write_tpl(3);
    send_image(18, 8, 0, -1, 0);
    count_check("R3");

    // R4: back-to-back images, next token right after the last pixel
    cur_req = "R4";
    write_tpl(6);
    send_image(17, 9, 0, -1, 0);
    send_image(16, 10, 0, -1, 0);
    send_image(24, 11, 0, -1, 0);
    count_check("R4");

    // R5: bubbles in the stream
    cur_req = "R5";
    write_tpl(1);
    send_image(22, 12, 3, -1, 0);
    send_image(18, 13, 5, -1, 0);
    count_check("R5");

    // R6: token in the middle of a column aborts the image
    cur_req = "R6";
    write_tpl(6);
    for (int c = 0; c < 17; c++)
      for (int r = 0; r < R; r++) pixel(pgen(14, c, r), (c == 0 && r == 0));
    for (int r = 0; r < 7; r++) pixel(pgen(14, 17, r), 0);
    send_image(18, 15, 0, -1, 0);
    count_check("R6");

    // R7: staging rewrite mid-image, after the token passed every element
    cur_req = "R7";
    write_tpl(1);
    send_image(22, 16, 0, 17, 2);
    send_image(18, 17, 0, -1, 0);
    count_check("R7");

    // R9: largest possible sum
    cur_req = "R9";
    write_tpl(0);
    send_image(17, -1, 0, -1, 0);
    count_check("R9");

    checks++;
    if (ready_bad) begin
      errors++; $display("FAIL R1: in_ready dropped, actual=0 expected=1");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule